// File: doc/BRIEF.md
# Class-Priority Eviction Selector

This block picks the cache slot to give up when a key/value store for transformer inference runs out of room. Each of its slots records whether it is occupied, whether it is pinned against eviction, a 3-bit eviction class set by the serving runtime, an 8-bit predicted-reuse score and the time of its last access. Recency does not drive the choice. The class decides first, the reuse score breaks ties inside a class, and age breaks ties after that.

The runtime writes slot state through an update port and refreshes access age through a touch port. An evict request takes a snapshot of every slot. A registered comparison tree then reduces the snapshot to one victim index, which appears a fixed number of cycles later. A new request can be issued on every cycle. If every slot is occupied and pinned, the result carries a "none" flag instead of an index. Moving or recomputing the victim's data is left to the surrounding logic.

Top module: `evict_victim_sel`

## Requirements
- R1: After reset every slot is empty and unpinned, res_valid, res_idx and res_none are 0, and the first evict request returns index 0 with res_none 0.
- R2: An update writes the addressed slot's occupied flag, pin flag, class and score, and stamps it with the current access time. An update with upd_valid 0 empties the slot and also clears its pin.
- R3: Any empty slot is chosen ahead of every occupied slot. Among empty slots the lowest index is chosen.
- R4: Among occupied slots the class rank decides first, with the lower rank chosen: code 0 (ephemeral tool call), then code 1 (low attention), then code 2 (cold), then code 3 (hot), then code 4 (reusable prefix). Codes 5 to 7 rank the same as code 4.
- R5: Within the same class rank, the slot with the lowest reuse score is chosen.
- R6: With equal rank and score, the slot with the older (smaller) access stamp is chosen. The stamp counter starts at 1 after reset, advances by one in every cycle that carries an update or a touch, and saturates at its maximum.
- R7: With equal rank, score and stamp, the lowest index is chosen. This includes two slots stamped in the same cycle by an update and a touch.
- R8: An occupied, pinned slot is never chosen. When every slot is occupied and pinned, the result has res_none 1 and res_idx 0.
- R9: A request sampled at a clock edge produces its result, with res_valid 1 for one cycle, after LAT = clog2(N_SLOTS)+1 edges counting that edge (6 for 32 slots). Requests may come back to back. While res_valid is 0, res_idx and res_none are 0.
- R10: An evict request evaluates the slot state as it stood before any update or touch applied at the same edge.
- R11: A touch sets the addressed slot's access stamp to the current time and leaves its occupied flag, pin, class and score unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_en | input | 1 | Write the slot selected by upd_idx |
| upd_idx | input | 5 | Slot to write |
| upd_valid | input | 1 | New occupied flag |
| upd_pin | input | 1 | New pin flag (ignored when upd_valid is 0) |
| upd_cls | input | 3 | New eviction class code |
| upd_score | input | 8 | New reuse score |
| touch_en | input | 1 | Refresh the access stamp of touch_idx |
| touch_idx | input | 5 | Slot to refresh |
| evict_req | input | 1 | Snapshot the slots and start a victim search |
| res_valid | output | 1 | Result of a search is present this cycle |
| res_idx | output | 5 | Chosen victim slot |
| res_none | output | 1 | No slot could be chosen (all pinned) |

## Verification
Two collisions are provoked on purpose. In the first, an evict request and an update that pins the only candidate arrive on the same edge. A second request follows on the next cycle. The first result must still name the slot, because it saw the state before the pin. The second must report none, and the two results must appear on consecutive cycles. In the second collision, an update and a touch on two slots with equal class and score land on the same edge, so both get the same stamp. The following search must then fall back to the lower index.

// File: rtl/evsel_pkg.sv
// Package: shared widths, class codes and the class-to-rank mapping used by
// the eviction victim selector. Assumes a 3-bit class code and 8-bit score.
package evsel_pkg;

    localparam int CLS_W   = 3;
    localparam int SCORE_W = 8;

    // Class codes written by the runtime; a lower rank is evicted first.
    typedef enum logic [CLS_W-1:0] {
        CLS_EPHEMERAL = 3'd0,
        CLS_LOW_ATTN  = 3'd1,
        CLS_COLD      = 3'd2,
        CLS_HOT       = 3'd3,
        CLS_PREFIX    = 3'd4
    } evict_cls_e;

    // Map a raw code onto its rank; undefined codes rank with the prefix class.
    function automatic logic [CLS_W-1:0] cls_rank(input logic [CLS_W-1:0] code);
        logic [CLS_W-1:0] top;
        top = CLS_PREFIX;
        return (code > top) ? top : code;
    endfunction

endpackage

// File: rtl/evsel_slot_file.sv
// Slot state store: one register set per slot plus a shared access-time
// counter. Assumes at most one update and one touch per cycle. An update
// wins over a touch to the same slot. Emptying a slot also drops its pin.
module evsel_slot_file
    import evsel_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int TS_W    = 16,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic [IDX_W-1:0]    upd_idx,
    input  logic                upd_valid,
    input  logic                upd_pin,
    input  logic [CLS_W-1:0]    upd_cls,
    input  logic [SCORE_W-1:0]  upd_score,
    input  logic                touch_en,
    input  logic [IDX_W-1:0]    touch_idx,
    output logic [N_SLOTS-1:0]  valid_v,
    output logic [N_SLOTS-1:0]  pin_v,
    output logic [CLS_W-1:0]    cls_a   [N_SLOTS],
    output logic [SCORE_W-1:0]  score_a [N_SLOTS],
    output logic [TS_W-1:0]     stamp_a [N_SLOTS],
    output logic [TS_W-1:0]     stamp_now
);

    localparam logic [TS_W-1:0] TS_MAX = '1;

    // Access-time counter: advances on each access cycle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_now <= TS_W'(1);
        end else if ((upd_en || touch_en) && (stamp_now != TS_MAX)) begin
            stamp_now <= stamp_now + 1'b1;
        end
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic                v_q;
        logic                p_q;
        logic [CLS_W-1:0]    c_q;
        logic [SCORE_W-1:0]  sc_q;
        logic [TS_W-1:0]     ts_q;
        logic                upd_hit;
        logic                touch_hit;

        assign upd_hit   = upd_en   && (upd_idx   == IDX_W'(s));
        assign touch_hit = touch_en && (touch_idx == IDX_W'(s));

        // Slot register set: full write on update, stamp-only on touch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q  <= 1'b0;
                p_q  <= 1'b0;
                c_q  <= '0;
                sc_q <= '0;
                ts_q <= '0;
            end else if (upd_hit) begin
                v_q  <= upd_valid;
                p_q  <= upd_valid & upd_pin;
                c_q  <= upd_cls;
                sc_q <= upd_score;
                ts_q <= stamp_now;
            end else if (touch_hit) begin
                ts_q <= stamp_now;
            end
        end

        assign valid_v[s] = v_q;
        assign pin_v[s]   = p_q;
        assign cls_a[s]   = c_q;
        assign score_a[s] = sc_q;
        assign stamp_a[s] = ts_q;
    end

endmodule

// File: rtl/evsel_key_stage.sv
// Snapshot stage: on a request, turns each slot into an eligibility bit and
// an ordering key, where a smaller key is the better victim. Empty slots get an
// all-zero key so they beat every occupied slot. Leaves beyond N_SLOTS are
// padding and never eligible. Assumes leaf order equals slot index order.
module evsel_key_stage
    import evsel_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int TS_W    = 16,
    localparam int LEAVES = 1 << $clog2(N_SLOTS),
    localparam int KEY_W  = 1 + CLS_W + SCORE_W + TS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic [N_SLOTS-1:0]  valid_v,
    input  logic [N_SLOTS-1:0]  pin_v,
    input  logic [CLS_W-1:0]    cls_a   [N_SLOTS],
    input  logic [SCORE_W-1:0]  score_a [N_SLOTS],
    input  logic [TS_W-1:0]     stamp_a [N_SLOTS],
    output logic [LEAVES-1:0]   leaf_elig,
    output logic [KEY_W-1:0]    leaf_key [LEAVES]
);

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < N_SLOTS) begin : g_live
            logic               e_q;
            logic [KEY_W-1:0]   k_q;
            logic [KEY_W-1:0]   k_c;

            // Key layout, most significant first: occupied, rank, score, stamp.
            always_comb begin
                k_c = valid_v[l] ? {1'b1, cls_rank(cls_a[l]), score_a[l], stamp_a[l]}
                                 : '0;
            end

            // Capture the leaf only when a search is requested.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    e_q <= 1'b0;
                    k_q <= '0;
                end else if (cap_en) begin
                    e_q <= !(valid_v[l] && pin_v[l]);
                    k_q <= k_c;
                end
            end

            assign leaf_elig[l] = e_q;
            assign leaf_key[l]  = k_q;
        end else begin : g_pad
            assign leaf_elig[l] = 1'b0;
            assign leaf_key[l]  = '0;
        end
    end

endmodule

// File: rtl/evsel_min_tree.sv
// Registered minimum tree over a power-of-two number of leaves, stored as a
// heap (node n has children 2n+1 and 2n+2; leaves occupy the last LEAVES
// positions in index order). One register level per tree level. On equal keys
// the left (lower-index) child wins. Latency from leaves to root: clog2(LEAVES).
module evsel_min_tree #(
    parameter int LEAVES = 32,
    parameter int KEY_W  = 28,
    localparam int IDX_W = $clog2(LEAVES),
    localparam int NODES = LEAVES - 1,
    localparam int HEAP  = 2 * LEAVES - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEAVES-1:0]  in_elig,
    input  logic [KEY_W-1:0]   in_key [LEAVES],
    output logic               out_elig,
    output logic [IDX_W-1:0]   out_idx
);

    logic [NODES-1:0]  n_elig;
    logic [KEY_W-1:0]  n_key [NODES];
    logic [IDX_W-1:0]  n_idx [NODES];

    logic [HEAP-1:0]   h_elig;
    logic [KEY_W-1:0]  h_key [HEAP];
    logic [IDX_W-1:0]  h_idx [HEAP];

    // Unified heap view: inner positions read node registers, leaves read inputs.
    for (genvar h = 0; h < HEAP; h++) begin : g_heap
        if (h < NODES) begin : g_inner
            assign h_elig[h] = n_elig[h];
            assign h_key[h]  = n_key[h];
            assign h_idx[h]  = n_idx[h];
        end else begin : g_leaf
            assign h_elig[h] = in_elig[h-NODES];
            assign h_key[h]  = in_key[h-NODES];
            assign h_idx[h]  = IDX_W'(h - NODES);
        end
    end

    // Every node keeps the better of its two children, one level per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_elig <= '0;
            for (int n = 0; n < NODES; n++) begin
                n_key[n] <= '0;
                n_idx[n] <= '0;
            end
        end else begin
            for (int n = 0; n < NODES; n++) begin
                if (h_elig[2*n+1] && (!h_elig[2*n+2] || (h_key[2*n+1] <= h_key[2*n+2]))) begin
                    n_elig[n] <= 1'b1;
                    n_key[n]  <= h_key[2*n+1];
                    n_idx[n]  <= h_idx[2*n+1];
                end else begin
                    n_elig[n] <= h_elig[2*n+2];
                    n_key[n]  <= h_key[2*n+2];
                    n_idx[n]  <= h_idx[2*n+2];
                end
            end
        end
    end

    assign out_elig = n_elig[0];
    assign out_idx  = n_idx[0];

endmodule

// File: rtl/evict_victim_sel.sv
// Top: class-priority eviction victim selector. Holds slot state, snapshots it
// on evict_req and returns the best victim LAT = clog2(N_SLOTS)+1 cycles later.
// Assumes N_SLOTS >= 2. One request per cycle is accepted; results stay in order.
module evict_victim_sel
    import evsel_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int TS_W    = 16,
    localparam int IDX_W  = $clog2(N_SLOTS),
    localparam int LEAVES = 1 << IDX_W,
    localparam int KEY_W  = 1 + CLS_W + SCORE_W + TS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic               upd_valid,
    input  logic               upd_pin,
    input  logic [CLS_W-1:0]   upd_cls,
    input  logic [SCORE_W-1:0] upd_score,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic               evict_req,
    output logic               res_valid,
    output logic [IDX_W-1:0]   res_idx,
    output logic               res_none
);

    logic [N_SLOTS-1:0]  valid_v;
    logic [N_SLOTS-1:0]  pin_v;
    logic [CLS_W-1:0]    cls_a   [N_SLOTS];
    logic [SCORE_W-1:0]  score_a [N_SLOTS];
    logic [TS_W-1:0]     stamp_a [N_SLOTS];
    logic [TS_W-1:0]     stamp_now;
    logic [LEAVES-1:0]   leaf_elig;
    logic [KEY_W-1:0]    leaf_key [LEAVES];
    logic                root_elig;
    logic [IDX_W-1:0]    root_idx;
    logic [IDX_W:0]      vld_q;

    evsel_slot_file #(.N_SLOTS(N_SLOTS), .TS_W(TS_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .upd_valid (upd_valid),
        .upd_pin   (upd_pin),
        .upd_cls   (upd_cls),
        .upd_score (upd_score),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .valid_v   (valid_v),
        .pin_v     (pin_v),
        .cls_a     (cls_a),
        .score_a   (score_a),
        .stamp_a   (stamp_a),
        .stamp_now (stamp_now)
    );

    evsel_key_stage #(.N_SLOTS(N_SLOTS), .TS_W(TS_W)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (evict_req),
        .valid_v   (valid_v),
        .pin_v     (pin_v),
        .cls_a     (cls_a),
        .score_a   (score_a),
        .stamp_a   (stamp_a),
        .leaf_elig (leaf_elig),
        .leaf_key  (leaf_key)
    );

    evsel_min_tree #(.LEAVES(LEAVES), .KEY_W(KEY_W)) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_elig  (leaf_elig),
        .in_key   (leaf_key),
        .out_elig (root_elig),
        .out_idx  (root_idx)
    );

    // Request tracker: one stage for the snapshot, one per tree level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[IDX_W-1:0], evict_req};
        end
    end

    assign res_valid = vld_q[IDX_W];
    assign res_none  = res_valid && !root_elig;
    assign res_idx   = (res_valid && root_elig) ? root_idx : '0;

endmodule

// File: rtl/evict_victim_sel_chk.sv
// Checker for evict_victim_sel: keeps its own delayed copy of request and
// slot eligibility so it can judge each result against the state it saw.
// Bound into every instance of the top module.
module evict_victim_sel_chk #(
    parameter int N_SLOTS = 32,
    parameter int TS_W    = 16,
    localparam int IDX_W  = $clog2(N_SLOTS),
    localparam int LAT    = IDX_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               evict_req,
    input logic               upd_en,
    input logic [IDX_W-1:0]   upd_idx,
    input logic               upd_valid,
    input logic               res_valid,
    input logic [IDX_W-1:0]   res_idx,
    input logic               res_none,
    input logic [N_SLOTS-1:0] valid_v,
    input logic [N_SLOTS-1:0] pin_v,
    input logic [TS_W-1:0]    stamp_now
);

    logic [LAT-1:0]     req_sr;
    logic [N_SLOTS-1:0] elig_sr [LAT];
    logic [N_SLOTS-1:0] empty_sr [LAT];
    logic [TS_W-1:0]    prev_ts_q;

    // Delay lines aligned with the design's result timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_sr    <= '0;
            prev_ts_q <= '0;
            for (int k = 0; k < LAT; k++) begin
                elig_sr[k]  <= '0;
                empty_sr[k] <= '0;
            end
        end else begin
            req_sr      <= {req_sr[LAT-2:0], evict_req};
            prev_ts_q   <= stamp_now;
            elig_sr[0]  <= ~(valid_v & pin_v);
            empty_sr[0] <= ~valid_v;
            for (int k = 1; k < LAT; k++) begin
                elig_sr[k]  <= elig_sr[k-1];
                empty_sr[k] <= empty_sr[k-1];
            end
        end
    end

    // R9: a result appears exactly LAT edges after its request.
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == req_sr[LAT-1]);

    // R9: outputs rest at zero between results.
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_idx == '0 && !res_none));

    // R8: "none" exactly when the snapshot had no eligible slot.
    a_r8_none_all_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_none == (elig_sr[LAT-1] == '0)));

    // R8: a pinned occupied slot is never returned.
    a_r8_never_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_none) |-> elig_sr[LAT-1][res_idx]);

    // R3: when the snapshot held an empty slot, an empty slot is returned.
    a_r3_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (empty_sr[LAT-1] != '0)) |-> (empty_sr[LAT-1][res_idx] && !res_none));

    // R2: emptying a slot also drops its pin.
    a_r2_empty_unpins: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_valid) |=> (!valid_v[$past(upd_idx)] && !pin_v[$past(upd_idx)]));

    // R6: the access clock never runs backwards.
    a_r6_stamp_mono: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_now >= prev_ts_q);

endmodule

bind evict_victim_sel evict_victim_sel_chk #(.N_SLOTS(N_SLOTS), .TS_W(TS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evict_req (evict_req),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_valid (upd_valid),
    .res_valid (res_valid),
    .res_idx   (res_idx),
    .res_none  (res_none),
    .valid_v   (valid_v),
    .pin_v     (pin_v),
    .stamp_now (stamp_now)
);

// File: tb/evict_victim_sel_bench.sv
// Bench: a vector table of operations walked by one loop, then directed
// collision and tie cases. Expected results are worked out by hand from the
// requirements.
module evict_victim_sel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 32;
    localparam int LAT = 6;
    localparam int OP_RST = 0, OP_UPD = 1, OP_TCH = 2, OP_EV = 3, OP_FILL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_en = 1'b0;
    logic [4:0] upd_idx = '0;
    logic       upd_valid = 1'b0;
    logic       upd_pin = 1'b0;
    logic [2:0] upd_cls = '0;
    logic [7:0] upd_score = '0;
    logic       touch_en = 1'b0;
    logic [4:0] touch_idx = '0;
    logic       evict_req = 1'b0;
    logic       res_valid;
    logic [4:0] res_idx;
    logic       res_none;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evict_victim_sel u_evict_victim_sel (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_idx(upd_idx),
        .upd_valid(upd_valid), .upd_pin(upd_pin), .upd_cls(upd_cls),
        .upd_score(upd_score), .touch_en(touch_en), .touch_idx(touch_idx),
        .evict_req(evict_req), .res_valid(res_valid), .res_idx(res_idx),
        .res_none(res_none)
    );

    function automatic logic [30:0] mk(input int op, input int idx, input int v, input int p,
                                       input int cls, input int sc, input int eidx,
                                       input int enone, input int rq);
        return {3'(op), 5'(idx), 1'(v), 1'(p), 3'(cls), 8'(sc), 5'(eidx), 1'(enone), 4'(rq)};
    endfunction

    localparam int NV = 31;
    localparam logic [30:0] VEC [NV] = '{
        mk(OP_RST, 0, 0,0,0,  0,  0,0, 1),
        mk(OP_EV,  0, 0,0,0,  0,  0,0, 1),   // R1 first search after reset
        mk(OP_UPD, 0, 1,0,0,  0,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0,  1,0, 3),   // R3 empty slot 1 beats ephemeral slot 0
        mk(OP_FILL,0, 0,0,0,  0,  0,0, 8),
        mk(OP_EV,  0, 0,0,0,  0,  0,1, 8),   // R8 all pinned -> none
        mk(OP_UPD, 7, 1,0,4,  0,  0,0, 2),
        mk(OP_UPD,20, 1,0,3,200,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0, 20,0, 4),   // R4 hot before prefix
        mk(OP_UPD,25, 1,0,2,255,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0, 25,0, 4),   // R4 cold before hot
        mk(OP_UPD,30, 1,0,1,255,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0, 30,0, 4),   // R4 low attention before cold
        mk(OP_UPD,31, 1,0,0,255,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0, 31,0, 4),   // R4 ephemeral first
        mk(OP_UPD, 3, 1,0,0,  9,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0,  3,0, 5),   // R5 lower score in class
        mk(OP_UPD, 2, 1,0,0,  9,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0,  3,0, 6),   // R6 older stamp beats lower index
        mk(OP_TCH, 3, 0,0,0,  0,  0,0,11),
        mk(OP_EV,  0, 0,0,0,  0,  2,0,11),   // R11 touch made slot 3 younger
        mk(OP_FILL,0, 0,0,0,  0,  0,0, 8),
        mk(OP_UPD, 9, 1,0,6,  0,  0,0, 2),
        mk(OP_UPD, 4, 1,0,4,  0,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0,  9,0, 4),   // R4 code 6 ranks with code 4
        mk(OP_UPD,10, 0,1,0,  0,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0, 10,0, 3),   // R3 emptied slot chosen (R2 pin dropped)
        mk(OP_UPD,10, 1,1,0,  0,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0,  9,0, 8),   // R8 pinned ephemeral skipped
        mk(OP_UPD, 9, 1,1,6,  0,  0,0, 2),
        mk(OP_EV,  0, 0,0,0,  0,  4,0, 8)    // R8 only slot 4 left
    };

    task automatic check(input logic ok, input int rq, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_upd(input int idx, input int v, input int p, input int cls, input int sc);
        upd_en = 1'b1; upd_idx = 5'(idx); upd_valid = 1'(v); upd_pin = 1'(p);
        upd_cls = 3'(cls); upd_score = 8'(sc);
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic do_touch(input int idx);
        touch_en = 1'b1; touch_idx = 5'(idx);
        @(negedge clk);
        touch_en = 1'b0;
    endtask

    task automatic do_fill();
        do_reset();
        for (int s = 0; s < N; s++) do_upd(s, 1, 1, 4, 255);
    endtask

    // Result is judged after LAT edges, counting the edge that samples the request.
    task automatic do_evict(input int eidx, input int enone, input int rq, input string what);
        evict_req = 1'b1;
        @(negedge clk);
        evict_req = 1'b0;
        repeat (LAT-1) @(negedge clk);
        check(res_valid && res_idx == 5'(eidx) && res_none == 1'(enone), rq, what,
              int'(res_valid) * 1000 + int'(res_none) * 100 + int'(res_idx),
              1000 + enone * 100 + eidx);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", 50000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: outputs at rest after reset
        check(!res_valid && res_idx == 0 && !res_none, 1, "reset outputs",
              int'(res_valid) * 100 + int'(res_idx), 0);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] w;
            w = VEC[i];
            case (int'(w[30:28]))
                OP_RST:  do_reset();
                OP_FILL: do_fill();
                OP_UPD:  do_upd(int'(w[27:23]), int'(w[22]), int'(w[21]), int'(w[20:18]), int'(w[17:10]));
                OP_TCH:  do_touch(int'(w[27:23]));
                default: do_evict(int'(w[9:5]), int'(w[4]), int'(w[3:0]), $sformatf("vector %0d", i));
            endcase
        end

        // R7: update and touch in one cycle give equal stamps; lower index wins.
        do_fill();
        do_upd(14, 1, 0, 1, 5);
        do_upd(12, 1, 0, 1, 5);
        upd_en = 1'b1; upd_idx = 5'd12; upd_valid = 1'b1; upd_pin = 1'b0;
        upd_cls = 3'd1; upd_score = 8'd5;
        touch_en = 1'b1; touch_idx = 5'd14;
        @(negedge clk);
        upd_en = 1'b0; touch_en = 1'b0;
        do_evict(12, 0, 7, "same stamp tie");

        // R10 and R9: evict plus pinning update on one edge, then a second request.
        do_fill();
        do_upd(6, 1, 0, 2, 1);
        evict_req = 1'b1;
        upd_en = 1'b1; upd_idx = 5'd6; upd_valid = 1'b1; upd_pin = 1'b1;
        upd_cls = 3'd2; upd_score = 8'd1;
        @(negedge clk);
        upd_en = 1'b0;
        @(negedge clk);
        evict_req = 1'b0;
        repeat (LAT-3) @(negedge clk);
        check(!res_valid && res_idx == 0 && !res_none, 9, "no result before latency",
              int'(res_valid), 0);
        @(negedge clk);
        check(res_valid && res_idx == 5'd6 && !res_none, 10, "snapshot before same-edge pin",
              int'(res_valid) * 1000 + int'(res_none) * 100 + int'(res_idx), 1006);
        @(negedge clk);
        check(res_valid && res_none && res_idx == 0, 9, "back-to-back second result none",
              int'(res_valid) * 1000 + int'(res_none) * 100 + int'(res_idx), 1100);
        @(negedge clk);
        check(!res_valid && res_idx == 0 && !res_none, 9, "idle after results",
              int'(res_valid) * 1000 + int'(res_none) * 100 + int'(res_idx), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule